// File: doc/BRIEF.md
# Deep Sleep Power Mode Controller

This block sequences a small processor system into and out of its lowest-power sleep state. Software reaches it through a narrow register port that holds a control word, a wake-cause word and two general-purpose words that survive sleep. Every register write is protected: it lands only when the identical write is issued on two back-to-back bus cycles. A single write, or a pair that is broken up, leaves the register unchanged.

To enter sleep, software arms the block with a protected write and then issues the sleep-instruction strobe in the very next cycle. If the strobe does not come in that cycle, the arm is dropped. The retention-regulator level seen when the arm lands selects the variant. In the retention variant execution resumes on wake. In the legacy variant the system restarts from the reset vector. While asleep the system clock is gated, I/O is frozen, and the low-power clock runs only when something needs it. Wake events end the sleep, and the highest-priority event is recorded one-hot. I/O stays frozen until software clears the release flag. A fresh arm is refused for three cycles after that clear.

Top module: `dslp_ctrl`

## Requirements
- R1: A register write commits only when two consecutive cycles carry `bus_wr` high with equal address and data. A lone write, a gap cycle between the halves, or a different write in between all leave the register unchanged.
- R2: The address map is 0 control, 1 wake cause (bits 4:0), 2 and 3 general-purpose 16-bit words. `bus_rdata` shows the register at `bus_addr` in the same cycle. Control bit 15 is the arm bit, bit 1 is the captured mode (read-only) and bit 0 is the release flag. Software can only clear the release flag and the cause bits. A write ANDs its data into them.
- R3: Once the arm bit is set, a `sleep_strobe` in the following cycle enters sleep at that clock edge. Without the strobe, the arm bit clears at that edge and sleep is not entered. A strobe while unarmed has no effect.
- R4: `ret_reg_en` is sampled when the arm commits. A 1 selects retention: `ret_active` is high while asleep and control bit 1 is 1. A 0 selects legacy. Later changes have no effect on the captured mode.
- R5: While asleep, `clk_gate` and `io_freeze` are 1, and control reads 0x8000 plus the mode bit plus the release flag (bit 0 set on entry).
- R6: While asleep, `lpclk_en` = `wdt_en` | (`rtc_en` & `rtc_lpclk_sel`). While awake it is 1.
- R7: `wake_evt` bits are: 0 power-on, 1 master clear, 2 RTC alarm, 3 external interrupt 0, 4 watchdog timeout. Any set bit while asleep wakes the block at the next edge and latches the lowest-index set bit one-hot into the cause register. Events while awake are ignored.
- R8: In the cycle after a wake edge, either `wake_resume` (retention) or `wake_reset` (legacy) is high for exactly one cycle. The arm bit is 0 from the wake edge on.
- R9: After wake, `io_freeze` stays 1 until a protected control write with bit 0 = 0 clears the release flag.
- R10: An arm write is refused while the release flag is set. It is also refused when its commit edge comes fewer than 3 edges after the edge that cleared the flag.
- R11: After reset, all registers read 0, `clk_gate`, `io_freeze`, `ret_active` and the wake pulses are 0, and `lpclk_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write request |
| bus_addr | input | 2 | Register address for write and read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of register at bus_addr |
| sleep_strobe | input | 1 | Sleep instruction executed |
| ret_reg_en | input | 1 | Retention regulator enabled |
| wake_evt | input | 5 | Wake event vector |
| wdt_en | input | 1 | Sleep watchdog enabled |
| rtc_en | input | 1 | Real-time clock enabled |
| rtc_lpclk_sel | input | 1 | Real-time clock runs from the low-power clock |
| clk_gate | output | 1 | System clock gated off |
| io_freeze | output | 1 | Hold I/O directions and levels |
| lpclk_en | output | 1 | Low-power clock enable |
| ret_active | output | 1 | Asleep in the retention variant |
| wake_resume | output | 1 | One-cycle pulse: resume execution |
| wake_reset | output | 1 | One-cycle pulse: restart at reset vector |

## Verification
The hardest case to reach is the three-cycle refusal window after the release flag clears. Reaching its boundary takes a protected clear followed by a protected arm whose second half lands exactly two or exactly three edges later. The stimulus gets there from a completed wake. It issues the clear pair and then the arm pair back to back, which must be refused. After a later wake it inserts one idle cycle between the pairs, which must be accepted. Simultaneous wake events are raised so that the priority encoding of the cause is exercised.

// File: rtl/dslp_pkg.sv
// Shared constants and helpers for the deep sleep controller.
package dslp_pkg;
    localparam int DATA_W    = 16;
    localparam int WAKE_N    = 5;
    localparam int ARM_BIT   = 15;
    localparam int MODE_BIT  = 1;
    localparam int REL_BIT   = 0;
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_CAUSE = 1;
    localparam int ADDR_GPR0 = 2;

    typedef enum logic {
        ST_AWAKE  = 1'b0,
        ST_ASLEEP = 1'b1
    } dslp_state_e;

    // Keep only the lowest-index set bit (highest wake priority).
    function automatic logic [WAKE_N-1:0] first_set(input logic [WAKE_N-1:0] v);
        logic [WAKE_N-1:0] r;
        r = '0;
        for (int i = WAKE_N - 1; i >= 0; i--) begin
            if (v[i]) begin
                r    = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/dslp_wr_guard.sv
// Protected-write filter.
// A write is passed on as a commit only when the same address and data
// arrive on two consecutive write cycles. Any idle cycle or differing write
// discards the pending first half.
// Assumes bus_wr is synchronous to clk.
module dslp_wr_guard #(
    parameter int AW = 2,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          commit,
    output logic [AW-1:0] c_addr,
    output logic [DW-1:0] c_data
);
    logic          pend_v;
    logic [AW-1:0] pend_a;
    logic [DW-1:0] pend_d;

    // Second half matches the pending first half.
    always_comb begin
        commit = wr_en && pend_v && (wr_addr == pend_a) && (wr_data == pend_d);
        c_addr = wr_addr;
        c_data = wr_data;
    end

    // Hold a first half for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= 1'b0;
            pend_a <= '0;
            pend_d <= '0;
        end else if (wr_en && !commit) begin
            pend_v <= 1'b1;
            pend_a <= wr_addr;
            pend_d <= wr_data;
        end else begin
            pend_v <= 1'b0;
        end
    end
endmodule

// File: rtl/dslp_regs.sv
// Register file of the deep sleep controller: control (arm, mode, release),
// wake cause and general-purpose retention words.
// Arm is accepted only when awake, with release clear and the post-release
// holdoff expired. Assumes commit comes from dslp_wr_guard.
module dslp_regs
    import dslp_pkg::*;
#(
    parameter int AW      = 2,
    parameter int DW      = DATA_W,
    parameter int NWAKE   = WAKE_N,
    parameter int NUM_GPR = 2,
    parameter int HOLDOFF = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [AW-1:0]    c_addr,
    input  logic [DW-1:0]    c_data,
    input  logic             ret_req,
    input  logic             asleep,
    input  logic             enter,
    input  logic             wake,
    input  logic [NWAKE-1:0] wake_onehot,
    input  logic             arm_drop,
    input  logic [AW-1:0]    rd_addr,
    output logic             arm,
    output logic             mode_ret,
    output logic             release_q,
    output logic [NWAKE-1:0] cause,
    output logic [DW-1:0]    rdata
);
    localparam int CW = $clog2(HOLDOFF + 1);
    localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLDOFF - 1);

    logic          ctrl_wr;
    logic          cause_wr;
    logic          arm_ok;
    logic          rel_clear;
    logic [CW-1:0] hold_cnt;
    logic [DW-1:0] gpr_q [NUM_GPR];

    // Decode committed writes and arm acceptance.
    always_comb begin
        ctrl_wr   = commit && (c_addr == AW'(ADDR_CTRL));
        cause_wr  = commit && (c_addr == AW'(ADDR_CAUSE));
        rel_clear = ctrl_wr && release_q && !c_data[REL_BIT];
        arm_ok    = ctrl_wr && c_data[ARM_BIT] && !release_q
                    && (hold_cnt == '0) && !asleep;
    end

    // Arm bit: set by accepted write, cleared by timeout, wake or write of 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            arm <= 1'b0;
        else if (arm_ok)
            arm <= 1'b1;
        else if (wake || arm_drop)
            arm <= 1'b0;
        else if (ctrl_wr && !c_data[ARM_BIT] && !asleep)
            arm <= 1'b0;
    end

    // Capture the sleep variant at the moment of arming.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_ret <= 1'b0;
        else if (arm_ok)
            mode_ret <= ret_req;
    end

    // Release flag: set on entry, cleared only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            release_q <= 1'b0;
        else if (enter)
            release_q <= 1'b1;
        else if (rel_clear)
            release_q <= 1'b0;
    end

    // Holdoff counter after the release flag is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_cnt <= '0;
        else if (rel_clear)
            hold_cnt <= HOLD_LOAD;
        else if (hold_cnt != '0)
            hold_cnt <= hold_cnt - 1'b1;
    end

    // Wake cause: latched on wake, software may only clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause <= '0;
        else if (wake)
            cause <= wake_onehot;
        else if (cause_wr)
            cause <= cause & c_data[NWAKE-1:0];
    end

    // One always_ff per general-purpose word.
    for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
        always_ff @(posedge clk) begin
            if (!rst_n)
                gpr_q[g] <= '0;
            else if (commit && (c_addr == AW'(ADDR_GPR0 + g)))
                gpr_q[g] <= c_data;
        end
    end

    // Combinational read mux.
    always_comb begin
        rdata = '0;
        if (rd_addr == AW'(ADDR_CTRL)) begin
            rdata[ARM_BIT]  = arm;
            rdata[MODE_BIT] = mode_ret;
            rdata[REL_BIT]  = release_q;
        end else if (rd_addr == AW'(ADDR_CAUSE)) begin
            rdata[NWAKE-1:0] = cause;
        end
        for (int i = 0; i < NUM_GPR; i++) begin
            if (rd_addr == AW'(ADDR_GPR0 + i))
                rdata = gpr_q[i];
        end
    end
endmodule

// File: rtl/dslp_seq.sv
// Awake/asleep sequencer.
// Enters sleep when armed and strobed in the same cycle, drops an unused arm,
// wakes on any event and emits the resume/reset pulse.
// Assumes arm is held for only one awake cycle by dslp_regs.
module dslp_seq
    import dslp_pkg::*;
#(
    parameter int NWAKE = WAKE_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             strobe,
    input  logic [NWAKE-1:0] wake_evt,
    input  logic             mode_ret,
    input  logic             wdt_en,
    input  logic             rtc_en,
    input  logic             rtc_lp,
    output logic             asleep,
    output logic             enter,
    output logic             wake,
    output logic             arm_drop,
    output logic [NWAKE-1:0] wake_onehot,
    output logic             lpclk_en,
    output logic             resume_q,
    output logic             restart_q
);
    dslp_state_e state;

    // Transition strobes derived from state and inputs.
    always_comb begin
        asleep      = (state == ST_ASLEEP);
        enter       = !asleep && arm && strobe;
        arm_drop    = !asleep && arm && !strobe;
        wake        = asleep && (|wake_evt);
        wake_onehot = first_set(wake_evt);
        lpclk_en    = !asleep || wdt_en || (rtc_en && rtc_lp);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_AWAKE;
        else if (enter)
            state <= ST_ASLEEP;
        else if (wake)
            state <= ST_AWAKE;
    end

    // One-cycle wake indication, resume or restart by captured mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume_q  <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            resume_q  <= wake && mode_ret;
            restart_q <= wake && !mode_ret;
        end
    end
endmodule

// File: rtl/dslp_ctrl.sv
// Deep sleep power mode controller, top level.
// Joins the protected-write filter, register file and sequencer and
// forms the clock gate, I/O freeze and retention outputs.
// Assumes a single clock domain and synchronous wake event inputs.
module dslp_ctrl
    import dslp_pkg::*;
#(
    parameter int NUM_GPR = 2,
    parameter int HOLDOFF = 3,
    parameter int AW      = $clog2(ADDR_GPR0 + NUM_GPR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sleep_strobe,
    input  logic              ret_reg_en,
    input  logic [WAKE_N-1:0] wake_evt,
    input  logic              wdt_en,
    input  logic              rtc_en,
    input  logic              rtc_lpclk_sel,
    output logic              clk_gate,
    output logic              io_freeze,
    output logic              lpclk_en,
    output logic              ret_active,
    output logic              wake_resume,
    output logic              wake_reset
);
    logic              commit;
    logic [AW-1:0]     c_addr;
    logic [DATA_W-1:0] c_data;
    logic              arm_q;
    logic              mode_q;
    logic              release_q;
    logic [WAKE_N-1:0] cause_q;
    logic              asleep;
    logic              enter;
    logic              wake;
    logic              arm_drop;
    logic [WAKE_N-1:0] wake_onehot;

    dslp_wr_guard #(.AW(AW), .DW(DATA_W)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .commit  (commit),
        .c_addr  (c_addr),
        .c_data  (c_data)
    );

    dslp_regs #(
        .AW(AW), .DW(DATA_W), .NWAKE(WAKE_N),
        .NUM_GPR(NUM_GPR), .HOLDOFF(HOLDOFF)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .c_addr      (c_addr),
        .c_data      (c_data),
        .ret_req     (ret_reg_en),
        .asleep      (asleep),
        .enter       (enter),
        .wake        (wake),
        .wake_onehot (wake_onehot),
        .arm_drop    (arm_drop),
        .rd_addr     (bus_addr),
        .arm         (arm_q),
        .mode_ret    (mode_q),
        .release_q   (release_q),
        .cause       (cause_q),
        .rdata       (bus_rdata)
    );

    dslp_seq #(.NWAKE(WAKE_N)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm_q),
        .strobe      (sleep_strobe),
        .wake_evt    (wake_evt),
        .mode_ret    (mode_q),
        .wdt_en      (wdt_en),
        .rtc_en      (rtc_en),
        .rtc_lp      (rtc_lpclk_sel),
        .asleep      (asleep),
        .enter       (enter),
        .wake        (wake),
        .arm_drop    (arm_drop),
        .wake_onehot (wake_onehot),
        .lpclk_en    (lpclk_en),
        .resume_q    (wake_resume),
        .restart_q   (wake_reset)
    );

    // Power-state outputs.
    always_comb begin
        clk_gate   = asleep;
        io_freeze  = asleep || release_q;
        ret_active = asleep && mode_q;
    end
endmodule

// File: rtl/dslp_ctrl_chk.sv
// Property checker for dslp_ctrl, attached by bind.
module dslp_ctrl_chk #(
    parameter int NWAKE = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             sleep_strobe,
    input logic             clk_gate,
    input logic             io_freeze,
    input logic             release_q,
    input logic             wake_resume,
    input logic             wake_reset,
    input logic [NWAKE-1:0] cause
);
    // R5
    freeze_covers_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_gate |-> io_freeze);

    // R3
    arm_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !clk_gate) |=> (clk_gate || !arm));

    // R3
    entry_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_gate) |-> $past(arm && sleep_strobe));

    // R8
    wake_pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wake_resume && wake_reset));

    // R8
    wake_pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_resume || wake_reset) |-> ($past(clk_gate) && !clk_gate));

    // R8
    arm_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_gate) |-> !arm);

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_gate && release_q) |-> io_freeze);

    // R7
    cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause));
endmodule

bind dslp_ctrl dslp_ctrl_chk #(.NWAKE(dslp_pkg::WAKE_N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm          (arm_q),
    .sleep_strobe (sleep_strobe),
    .clk_gate     (clk_gate),
    .io_freeze    (io_freeze),
    .release_q    (release_q),
    .wake_resume  (wake_resume),
    .wake_reset   (wake_reset),
    .cause        (cause_q)
);

// File: tb/dslp_ctrl_bench.sv
`timescale 1ns/1ps
module dslp_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sleep_strobe = 1'b0;
    logic        ret_reg_en = 1'b0;
    logic [4:0]  wake_evt = '0;
    logic        wdt_en = 1'b0;
    logic        rtc_en = 1'b0;
    logic        rtc_lpclk_sel = 1'b0;
    logic        clk_gate, io_freeze, lpclk_en, ret_active, wake_resume, wake_reset;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    dslp_ctrl u_dslp_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_strobe(sleep_strobe),
        .ret_reg_en(ret_reg_en), .wake_evt(wake_evt), .wdt_en(wdt_en),
        .rtc_en(rtc_en), .rtc_lpclk_sel(rtc_lpclk_sel), .clk_gate(clk_gate),
        .io_freeze(io_freeze), .lpclk_en(lpclk_en), .ret_active(ret_active),
        .wake_resume(wake_resume), .wake_reset(wake_reset)
    );

    // {addr, data, twice, expected readback}
    localparam logic [34:0] VEC [8] = '{
        {2'd2, 16'hA5A5, 1'b1, 16'hA5A5},
        {2'd3, 16'h1234, 1'b0, 16'h0000},
        {2'd3, 16'h1234, 1'b1, 16'h1234},
        {2'd2, 16'hFFFF, 1'b0, 16'hA5A5},
        {2'd2, 16'h0F0F, 1'b1, 16'h0F0F},
        {2'd0, 16'h0003, 1'b1, 16'h0000},
        {2'd1, 16'h001F, 1'b1, 16'h0000},
        {2'd3, 16'h0000, 1'b1, 16'h0000}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at a negedge with bus_wr low.
    task automatic bwr(input logic [1:0] a, input logic [15:0] d, input int n);
        for (int i = 0; i < n; i++) begin
            bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
            @(negedge clk);
        end
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        @(negedge clk);
    endtask

    // Protected control write, then strobe (or not) in the next cycle.
    task automatic arm_try(input logic [15:0] d, input logic s);
        bwr(2'd0, d, 2);
        sleep_strobe = s;
        @(negedge clk);
        sleep_strobe = 1'b0;
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog timeout");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        chk("R11 clk_gate", {15'd0, clk_gate}, 16'd0);
        chk("R11 io_freeze", {15'd0, io_freeze}, 16'd0);
        chk("R11 lpclk_en", {15'd0, lpclk_en}, 16'd1);
        chk("R11 pulses", {14'd0, wake_resume, wake_reset}, 16'd0);
        @(negedge clk);
        rd("R11 ctrl", 2'd0, 16'h0000);
        rd("R11 gpr0", 2'd2, 16'h0000);

        // R1 R2 vector table
        for (int v = 0; v < 8; v++) begin
            bwr(VEC[v][34:33], VEC[v][32:17], VEC[v][16] ? 2 : 1);
            rd($sformatf("R1 R2 vec%0d", v), VEC[v][34:33], VEC[v][15:0]);
        end

        // R1 interleaved write cancels: X, Y, X
        bwr(2'd2, 16'hBEEF, 1); bwr(2'd3, 16'h5555, 1);
        bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 16'hBEEF;
        @(negedge clk); bus_wr = 1'b0;
        rd("R1 cancel gpr0", 2'd2, 16'h0F0F);
        rd("R1 cancel gpr1", 2'd3, 16'h0000);
        // R1 gap cycle between halves
        bwr(2'd3, 16'h7777, 1); @(negedge clk); bwr(2'd3, 16'h7777, 1);
        rd("R1 gap gpr1", 2'd3, 16'h0000);

        // R3 strobe while unarmed
        sleep_strobe = 1'b1; @(negedge clk); sleep_strobe = 1'b0; #1;
        chk("R3 unarmed strobe", {15'd0, clk_gate}, 16'd0);
        @(negedge clk);
        // R3 arm without strobe: visible in window, then dropped
        bwr(2'd0, 16'h8000, 2);
        rd("R3 arm window", 2'd0, 16'h8000);
        rd("R3 arm dropped", 2'd0, 16'h0000);
        chk("R3 no entry", {15'd0, clk_gate}, 16'd0);

        // Legacy sleep
        arm_try(16'h8000, 1'b1); #1;
        chk("R5 clk_gate", {15'd0, clk_gate}, 16'd1);
        chk("R5 io_freeze", {15'd0, io_freeze}, 16'd1);
        chk("R6 lpclk off", {15'd0, lpclk_en}, 16'd0);
        chk("R4 legacy", {15'd0, ret_active}, 16'd0);
        @(negedge clk); wdt_en = 1'b1; #1;
        chk("R6 lpclk wdt", {15'd0, lpclk_en}, 16'd1);
        @(negedge clk);
        rd("R5 ctrl asleep", 2'd0, 16'h8001);
        wake_evt = 5'b01100; @(negedge clk); wake_evt = '0; #1;
        chk("R8 wake_reset", {14'd0, wake_resume, wake_reset}, 16'd1);
        chk("R8 awake", {15'd0, clk_gate}, 16'd0);
        chk("R9 freeze held", {15'd0, io_freeze}, 16'd1);
        @(negedge clk); #1;
        chk("R8 pulse width", {14'd0, wake_resume, wake_reset}, 16'd0);
        @(negedge clk); wdt_en = 1'b0;
        rd("R7 cause alarm", 2'd1, 16'h0004);
        rd("R8 arm cleared", 2'd0, 16'h0001);

        // R7 wake event while awake ignored
        wake_evt = 5'b10000; @(negedge clk); wake_evt = '0; #1;
        chk("R7 awake event", {13'd0, clk_gate, wake_resume, wake_reset}, 16'd0);
        @(negedge clk);
        rd("R7 cause kept", 2'd1, 16'h0004);

        // R10 arm refused while release set
        arm_try(16'h8001, 1'b1); #1;
        chk("R10 refused release", {15'd0, clk_gate}, 16'd0);
        @(negedge clk);
        // R9 clear release, R10 immediate arm refused
        bwr(2'd0, 16'h0000, 2);
        arm_try(16'h8000, 1'b1); #1;
        chk("R10 refused holdoff", {15'd0, clk_gate}, 16'd0);
        chk("R9 freeze released", {15'd0, io_freeze}, 16'd0);
        @(negedge clk);

        // Retention sleep
        ret_reg_en = 1'b1;
        arm_try(16'h8000, 1'b1); #1;
        chk("R4 ret_active", {15'd0, ret_active}, 16'd1);
        @(negedge clk); ret_reg_en = 1'b0; rtc_en = 1'b1; rtc_lpclk_sel = 1'b1; #1;
        chk("R4 mode kept", {15'd0, ret_active}, 16'd1);
        chk("R6 lpclk rtc", {15'd0, lpclk_en}, 16'd1);
        @(negedge clk); rtc_lpclk_sel = 1'b0; #1;
        chk("R6 rtc other clock", {15'd0, lpclk_en}, 16'd0);
        @(negedge clk);
        rd("R4 ctrl mode", 2'd0, 16'h8003);
        wake_evt = 5'b10001; @(negedge clk); wake_evt = '0; rtc_en = 1'b0; #1;
        chk("R8 wake_resume", {14'd0, wake_resume, wake_reset}, 16'd2);
        @(negedge clk);
        rd("R7 cause por", 2'd1, 16'h0001);
        rd("R2 gpr kept", 2'd2, 16'h0F0F);

        // R10 boundary: arm commit exactly 3 edges after release clear
        bwr(2'd0, 16'h0000, 2);
        @(negedge clk);
        arm_try(16'h8000, 1'b1); #1;
        chk("R10 accepted at 3", {15'd0, clk_gate}, 16'd1);
        chk("R4 legacy again", {15'd0, ret_active}, 16'd0);
        @(negedge clk);
        wake_evt = 5'b00010; @(negedge clk); wake_evt = '0; #1;
        chk("R8 legacy restart", {14'd0, wake_resume, wake_reset}, 16'd1);
        @(negedge clk);
        rd("R7 cause mclr", 2'd1, 16'h0002);
        bwr(2'd1, 16'h0000, 2);
        rd("R2 cause clear", 2'd1, 16'h0000);

        summary();
        $finish;
    end
endmodule